// File: doc/BRIEF.md
# Aging-Counter Page Victim Selector

This block approximates least-recently-used page replacement in hardware. It keeps one history register per page, plus one "touched" flag per page. A reference input marks a page as touched. A periodic tick folds every page's touched flag into the top bit of that page's history and moves the older history one place toward the least significant end. The touched flags then start over for the next interval.

When a fault request arrives, the block searches all histories for the smallest value. One cycle later it returns the winning page as the eviction victim. Software or a paging engine uses the victim index to decide which frame to reuse. All history registers can be read on a flat vector.

Top module: `page_aging_victim`

## Requirements
- R1: After reset every history register reads zero and `victim_valid` is low.
- R2: On a cycle with `tick` high, each page's history becomes {touched flag, history[7:1]}. The lowest bit is dropped.
- R3: A reference (`ref_valid` high with `ref_page`) sets that page's touched flag. The flag is sampled at the next tick. Several references to one page in an interval count the same as one.
- R4: A tick clears all touched flags. A page that is not referenced during an interval receives a 0 in its top bit at the following tick.
- R5: A reference made in the same cycle as a tick is not seen by that tick. It is kept for the next tick.
- R6: Without a tick, references and fault requests leave every history register unchanged.
- R7: `victim_valid` is high exactly in the cycle after a cycle with `fault_req` high. `victim_page` then names a page whose history held the smallest value.
- R8: When several pages share the smallest history value, the lowest page index is reported.
- R9: A fault request made in the same cycle as a tick is decided on the history values from before that tick.
- R10: `age_vec` exposes page i's history at bits [8*i+7 : 8*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A page is referenced this cycle |
| ref_page | input | 3 | Index of the referenced page |
| tick | input | 1 | Aging interval boundary |
| fault_req | input | 1 | Request a victim decision |
| victim_valid | output | 1 | Victim index is valid this cycle |
| victim_page | output | 3 | Page chosen for eviction |
| age_vec | output | 64 | All history registers, page i at bits [8*i+7:8*i] |

## Verification
The bench goes after several corner cases:
- Ties on the minimum. A design that uses a non-strict compare would return the highest tied index instead of the lowest.
- A reference landing in the same cycle as a tick. A design that lets it reach the current tick, or that drops it, would show the wrong top bit one interval early or never.
- A fault request arriving on a tick. A design that compares post-tick histories picks a different page in the chosen scenario.
- Repeated references and references without a tick. These would expose a design that counts references or ages without the timer.

// File: rtl/page_aging_victim.sv
module page_aging_victim #(
  parameter int NUM_PAGES = 8,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_valid,
  input  logic [IDX_W-1:0]           ref_page,
  input  logic                       tick,
  input  logic                       fault_req,
  output logic                       victim_valid,
  output logic [IDX_W-1:0]           victim_page,
  output logic [NUM_PAGES*AGE_W-1:0] age_vec
);

  logic [AGE_W-1:0]     hist_q [NUM_PAGES];
  logic [NUM_PAGES-1:0] touched_q, touch_now;
  logic [IDX_W-1:0]     min_idx;
  logic [AGE_W-1:0]     min_val;

  assign touch_now = ref_valid ? ({{(NUM_PAGES-1){1'b0}}, 1'b1} << ref_page) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     touched_q <= '0;
    else if (tick)  touched_q <= touch_now;
    else            touched_q <= touched_q | touch_now;
  end

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)    hist_q[g] <= '0;
      else if (tick) hist_q[g] <= {touched_q[g], hist_q[g][AGE_W-1:1]};
    end
    assign age_vec[g*AGE_W +: AGE_W] = hist_q[g];
  end

  always_comb begin
    min_idx = '0;
    min_val = hist_q[0];
    for (int i = 1; i < NUM_PAGES; i++) begin
      if (hist_q[i] < min_val) begin
        min_val = hist_q[i];
        min_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_valid <= 1'b0;
      victim_page  <= '0;
    end else begin
      victim_valid <= fault_req;
      if (fault_req) victim_page <= min_idx;
    end
  end

endmodule

// File: rtl/page_aging_victim_chk.sv
module page_aging_victim_chk #(
  parameter int NUM_PAGES = 8,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       fault_req,
  input logic                       victim_valid,
  input logic [IDX_W-1:0]           victim_page,
  input logic [NUM_PAGES*AGE_W-1:0] age_vec
);

  logic [NUM_PAGES*AGE_W-1:0] age_d;
  logic                       min_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) age_d <= '0;
    else        age_d <= age_vec;
  end

  always_comb begin
    min_ok = 1'b1;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (age_d[i*AGE_W +: AGE_W] < age_d[int'(victim_page)*AGE_W +: AGE_W]) min_ok = 1'b0;
      if (i < int'(victim_page) &&
          age_d[i*AGE_W +: AGE_W] == age_d[int'(victim_page)*AGE_W +: AGE_W]) min_ok = 1'b0;
    end
  end

  p_victim_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> victim_valid);
  p_no_spurious_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_req |=> !victim_valid);
  p_victim_is_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> min_ok);
  p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(age_vec));

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_shift
    p_shift_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> age_vec[g*AGE_W +: AGE_W-1] == $past(age_vec[g*AGE_W+1 +: AGE_W-1]));
  end

endmodule

bind page_aging_victim page_aging_victim_chk #(
  .NUM_PAGES(NUM_PAGES), .AGE_W(AGE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fault_req(fault_req),
  .victim_valid(victim_valid), .victim_page(victim_page), .age_vec(age_vec)
);

// File: tb/sim_page_aging_victim.sv
`timescale 1ns/1ps
module sim_page_aging_victim;
  logic        clk = 1'b0;
  logic        rst_n, ref_valid, tick, fault_req;
  logic [2:0]  ref_page;
  logic        victim_valid;
  logic [2:0]  victim_page;
  logic [63:0] age_vec;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [8];
  logic [7:0] mdl_ref;

  always #2 clk = ~clk;

  page_aging_victim u0 (.clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
    .tick(tick), .fault_req(fault_req), .victim_valid(victim_valid),
    .victim_page(victim_page), .age_vec(age_vec));

  // each entry: {reference mask, expected victim}
  localparam logic [10:0] VEC [6] = '{
    {8'b0000_0101, 3'd1}, {8'b0001_0001, 3'd1}, {8'b0010_1001, 3'd1},
    {8'b1111_1110, 3'd0}, {8'b0000_0001, 3'd1}, {8'b0000_0010, 3'd6}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mdl_vec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; ref_valid = 0; ref_page = 0; tick = 0; fault_req = 0;
    step(); step(); rst_n = 1;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    mdl_ref = '0;
  endtask

  task automatic touch(int p);
    ref_valid = 1; ref_page = 3'(p); step(); ref_valid = 0;
    mdl_ref[p] = 1'b1;
  endtask

  task automatic do_tick();
    tick = 1; step(); tick = 0;
    for (int i = 0; i < 8; i++) mdl[i] = {mdl_ref[i], mdl[i][7:1]};
    mdl_ref = '0;
  endtask

  task automatic fault_check(string req, logic [2:0] exp);
    fault_req = 1; step(); fault_req = 0;
    chk(req, {63'd0, victim_valid}, 64'd1);
    chk(req, {61'd0, victim_page}, {61'd0, exp});
    step();
    chk("R7 valid drops", {63'd0, victim_valid}, 64'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 ages zero", age_vec, 64'd0);
    chk("R1 victim_valid low", {63'd0, victim_valid}, 64'd0);
    fault_check("R8 all-zero tie", 3'd0);

    for (int v = 0; v < 6; v++) begin
      for (int p = 0; p < 8; p++) if (VEC[v][3+p]) touch(p);
      if (v == 0) touch(0);
      chk("R6 refs without tick", age_vec, mdl_vec());
      do_tick();
      chk("R2 R3 R4 R10 aged vector", age_vec, mdl_vec());
      fault_check("R7 R8 victim", VEC[v][2:0]);
      chk("R6 fault keeps ages", age_vec, mdl_vec());
    end

    // R5: reference in the tick cycle waits for the next tick
    do_reset();
    ref_valid = 1; ref_page = 3'd3; tick = 1; step(); ref_valid = 0; tick = 0;
    chk("R5 same-cycle ref not sampled", age_vec, 64'd0);
    tick = 1; step(); tick = 0;
    chk("R5 ref kept for next tick", age_vec, 64'h0000_0000_8000_0000);
    tick = 1; step(); tick = 0;
    chk("R4 flag cleared after tick", age_vec, 64'h0000_0000_4000_0000);

    // R9: fault and tick together use pre-tick ages
    do_reset();
    for (int p = 1; p < 8; p++) touch(p);
    do_tick();
    touch(0);
    tick = 1; fault_req = 1; step(); tick = 0; fault_req = 0;
    chk("R9 valid", {63'd0, victim_valid}, 64'd1);
    chk("R9 pre-tick victim", {61'd0, victim_page}, 64'd0);
    chk("R9 post-tick ages", age_vec, 64'h4040_4040_4040_4080);
    step();
    fault_check("R7 post-tick victim", 3'd1);

    // R1: reset mid-run
    rst_n = 0; step(); rst_n = 1;
    chk("R1 mid-run reset", age_vec, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule